// File: doc/BRIEF.md
# Multiplexed LED Bank Scanner with Segment Decoder

This block drives a five-digit common-cathode LED display from two held registers: a 24-bit display word and an 8-bit configuration byte. It turns on one cathode bank at a time in a fixed rotation. While a bank is on, it decodes that bank's 4-bit nibble into segments a to g. Each bank uses its own decode mode: hexadecimal, a fixed table of letters and symbols, or a raw lamp pass-through. The decimal-point segment h is driven from a shared 3-bit code, and a brightness flag is passed to the analog drivers.

The scan rate is set by two parameters, the system clock frequency and the target full-scan rate. Each bank slot lasts `BANK_CYCLES = CLK_HZ / (SCAN_HZ * 5)` system clocks. A load strobe tells the block that new register contents are present. The block then darkens the display for one bank slot and restarts the rotation at bank 1. A low-power bit in the configuration byte stops the scan and holds every output dark.

Top module: `led_bank_scanner`

## Requirements
- R1: `bank_en` is one-hot or zero. Bank 1 (`bank_en[0]`) through bank 5 (`bank_en[4]`) are served in that order and then the order repeats. Each bank owns a slot of `BANK_CYCLES` clocks, and the full scan takes `5*BANK_CYCLES` clocks.
- R2: The first clock of every bank slot is dark, with `bank_en` = 0 and `seg` = 0. `bank_en` therefore never moves directly from one bank to another.
- R3: Hex mode maps the nibble to `seg[6:0]` (bit 0 = a ... bit 6 = g), values 0..F in order: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R4: Special mode maps the nibble, values 0..F in order, to: 00 58 76 74 1E 38 54 5C 73 50 3E 1C 6E 40 48 63. Value 0 is blank.
- R5: Raw mode drives `seg[3:0]` with the nibble bits and forces `seg[6:4]` to 0.
- R6: Bank k (1..5) takes its nibble from `disp_reg[4k-1:4k-4]`.
  - When `cfg_reg[k]` = 0, the bank uses hex mode.
  - When `cfg_reg[k]` = 1, banks 1 to 3 use special mode if `cfg_reg[6]` = 1 and raw mode otherwise.
  - When `cfg_reg[k]` = 1, banks 4 and 5 follow `cfg_reg[7]` in the same way.
- R7: `seg[7]` (h) follows the code `disp_reg[22:20]`, in every decode mode:
  - 0: h off in every bank.
  - 1 to 5: h on only in bank 1 to bank 5 respectively.
  - 6: h on in every bank.
  - 7: h on in banks 1 and 2.
- R8: While `cfg_reg[0]` = 0, the block is in low power. From the next clock on, `bank_en` and `seg` stay 0 and the scan is held at the start of bank 1. A load in the same cycle has no further effect. When `cfg_reg[0]` returns to 1, bank 1's slot starts in that clock.
- R9: A cycle with `load` = 1 darkens `bank_en` and `seg` from the next clock. They stay dark for that clock plus one full bank slot. Bank 1's slot, including its dark first clock, then starts.
- R10: `dim` equals the inverse of `disp_reg[23]`, one clock late.
- R11: During reset, `bank_en`, `seg` and `dim` are all 0. After reset is released, bank 1's slot starts in the first clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_reg | input | 24 | Display word: five nibbles, h code, brightness bit |
| cfg_reg | input | 8 | Configuration byte: run bit, per-bank mode bits, group mode bits |
| load | input | 1 | One-clock strobe marking a register update |
| bank_en | output | 5 | One-hot cathode bank enables, bank 1 in bit 0 |
| seg | output | 8 | Segments a to g in bits 0 to 6, h in bit 7 |
| dim | output | 1 | High when the display is to be driven at reduced brightness |

## Verification
A load strobe or a low-power entry can land on the same clock as a bank transition, which is the last phase of a slot. A load can also arrive in the same clock as a low-power request. The sweep stretches each run by a varying number of clocks, so successive loads land on every phase of every bank, including the final phase and the dark gap. One test raises load in the cycle that enters low power. Each case is judged with a cycle-exact model of the slot position counted from the strobe or from leaving low power: the bench expects darkness through the blank slot and then bank 1 with its gap, while low power overrides the load outright.

// File: rtl/led_scan_pkg.sv
// Shared constants and types for the LED bank scanner.
package led_scan_pkg;
    // Number of cathode banks; fixed by the layout of the display word.
    localparam int NUM_BANKS = 5;
    // Width of the bank index.
    localparam int BANK_IDX_W = 3;
    // Segments a..g.
    localparam int GLYPH_W = 7;

    // Decode mode of one bank.
    typedef enum logic [1:0] {
        MODE_HEX     = 2'd0,
        MODE_SPECIAL = 2'd1,
        MODE_RAW     = 2'd2
    } dec_mode_t;
endpackage

// File: rtl/lbs_scan_timer.sv
// Bank rotation timer.
// Counts the clocks inside a bank slot and advances the bank index 0..4.
// A load opens a blank slot of BANK_CYCLES clocks and then restarts at bank 0.
// While run is low, the scan is held at bank 0, phase 0.
// drive_on is high only outside the blank slot and outside the first (gap)
// clock of a slot.
// Assumes BANK_CYCLES >= 2.
module lbs_scan_timer
    import led_scan_pkg::*;
#(
    parameter int BANK_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  load,
    output logic [BANK_IDX_W-1:0] bank_idx,
    output logic                  drive_on
);
    localparam int PH_W = (BANK_CYCLES > 2) ? $clog2(BANK_CYCLES) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BANK_CYCLES - 1);
    localparam logic [BANK_IDX_W-1:0] IDX_LAST = BANK_IDX_W'(NUM_BANKS - 1);

    logic [PH_W-1:0]       phase;
    logic [BANK_IDX_W-1:0] bank;
    logic                  blanking;

    // Advance the phase and bank counters; enter or leave blanking.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase    <= '0;
            bank     <= '0;
            blanking <= 1'b0;
        end else if (load) begin
            phase    <= '0;
            bank     <= '0;
            blanking <= 1'b1;
        end else if (phase == PH_LAST) begin
            phase <= '0;
            if (blanking) begin
                blanking <= 1'b0;
                bank     <= '0;
            end else if (bank == IDX_LAST) begin
                bank <= '0;
            end else begin
                bank <= bank + 1'b1;
            end
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign bank_idx = bank;
    assign drive_on = run && !load && !blanking && (phase != '0);
endmodule

// File: rtl/lbs_mode_select.sv
// Per-bank decode mode selection.
// Builds each bank's mode from its own configuration bit and its group's bit,
// then picks the mode of the bank currently being scanned.
// Banks 0..2 belong to group bit 6; banks 3..4 belong to group bit 7.
module lbs_mode_select
    import led_scan_pkg::*;
(
    input  logic [7:0]            cfg,
    input  logic [BANK_IDX_W-1:0] bank_idx,
    output dec_mode_t             mode
);
    dec_mode_t bank_mode [NUM_BANKS];

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        localparam int GRP_BIT = (k < 3) ? 6 : 7;
        // Resolve the mode of bank k.
        always_comb begin
            if (!cfg[k+1])         bank_mode[k] = MODE_HEX;
            else if (cfg[GRP_BIT]) bank_mode[k] = MODE_SPECIAL;
            else                   bank_mode[k] = MODE_RAW;
        end
    end

    // Pick the mode of the bank being scanned.
    always_comb begin
        mode = MODE_HEX;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (bank_idx == BANK_IDX_W'(k)) mode = bank_mode[k];
        end
    end
endmodule

// File: rtl/lbs_glyph_decoder.sv
// Nibble to segments a..g decoder, bit 0 = a ... bit 6 = g.
// Supports hex glyphs, a fixed letter/symbol table, and raw lamp pass-through.
// Purely combinational; assumes the nibble and mode belong to the same bank.
module lbs_glyph_decoder
    import led_scan_pkg::*;
(
    input  logic [3:0]         nibble,
    input  dec_mode_t          mode,
    output logic [GLYPH_W-1:0] glyph
);
    logic [GLYPH_W-1:0] hex_g;
    logic [GLYPH_W-1:0] spc_g;

    // Hexadecimal glyphs.
    always_comb begin
        case (nibble)
            4'h0: hex_g = 7'h3F;
            4'h1: hex_g = 7'h06;
            4'h2: hex_g = 7'h5B;
            4'h3: hex_g = 7'h4F;
            4'h4: hex_g = 7'h66;
            4'h5: hex_g = 7'h6D;
            4'h6: hex_g = 7'h7D;
            4'h7: hex_g = 7'h07;
            4'h8: hex_g = 7'h7F;
            4'h9: hex_g = 7'h6F;
            4'hA: hex_g = 7'h77;
            4'hB: hex_g = 7'h7C;
            4'hC: hex_g = 7'h39;
            4'hD: hex_g = 7'h5E;
            4'hE: hex_g = 7'h79;
            default: hex_g = 7'h71;
        endcase
    end

    // Letters and symbols: blank c H h J L n o P r U u y - = degree.
    always_comb begin
        case (nibble)
            4'h0: spc_g = 7'h00;
            4'h1: spc_g = 7'h58;
            4'h2: spc_g = 7'h76;
            4'h3: spc_g = 7'h74;
            4'h4: spc_g = 7'h1E;
            4'h5: spc_g = 7'h38;
            4'h6: spc_g = 7'h54;
            4'h7: spc_g = 7'h5C;
            4'h8: spc_g = 7'h73;
            4'h9: spc_g = 7'h50;
            4'hA: spc_g = 7'h3E;
            4'hB: spc_g = 7'h1C;
            4'hC: spc_g = 7'h6E;
            4'hD: spc_g = 7'h40;
            4'hE: spc_g = 7'h48;
            default: spc_g = 7'h63;
        endcase
    end

    // Select the glyph for the active mode.
    always_comb begin
        case (mode)
            MODE_SPECIAL: glyph = spc_g;
            MODE_RAW:     glyph = {3'b000, nibble};
            default:      glyph = hex_g;
        endcase
    end
endmodule

// File: rtl/lbs_point_decoder.sv
// Decimal-point (segment h) decoder.
// Decides from the shared 3-bit code whether h is lit in the scanned bank.
// Code 0 = none, 1..5 = one bank, 6 = every bank, 7 = banks 0 and 1.
module lbs_point_decoder
    import led_scan_pkg::*;
(
    input  logic [2:0]            code,
    input  logic [BANK_IDX_W-1:0] bank_idx,
    output logic                  point
);
    // Match the code against the scanned bank.
    always_comb begin
        case (code)
            3'd0:    point = 1'b0;
            3'd6:    point = 1'b1;
            3'd7:    point = (bank_idx < BANK_IDX_W'(2));
            default: point = (bank_idx == BANK_IDX_W'(code - 3'd1));
        endcase
    end
endmodule

// File: rtl/led_bank_scanner.sv
// Multiplexed LED bank scanner, top level.
// Rotates five cathode banks, decodes the scanned bank's nibble and h bit, and
// registers every output.
// Assumes disp_reg and cfg_reg are held stable by their owner. load marks
// an update.
module led_bank_scanner
    import led_scan_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int SCAN_HZ = 1_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] disp_reg,
    input  logic [7:0]  cfg_reg,
    input  logic        load,
    output logic [4:0]  bank_en,
    output logic [7:0]  seg,
    output logic        dim
);
    localparam int BANK_CYCLES = CLK_HZ / (SCAN_HZ * NUM_BANKS);

    logic [BANK_IDX_W-1:0] bank_idx;
    logic                  drive_on;
    logic [3:0]            nibble;
    dec_mode_t             mode;
    logic [GLYPH_W-1:0]    glyph;
    logic                  point;
    logic [NUM_BANKS-1:0]  bank_onehot;

    lbs_scan_timer #(.BANK_CYCLES(BANK_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg_reg[0]),
        .load     (load),
        .bank_idx (bank_idx),
        .drive_on (drive_on)
    );

    lbs_mode_select u_mode (
        .cfg      (cfg_reg),
        .bank_idx (bank_idx),
        .mode     (mode)
    );

    // Pick the scanned bank's nibble.
    always_comb begin
        case (bank_idx)
            3'd1:    nibble = disp_reg[7:4];
            3'd2:    nibble = disp_reg[11:8];
            3'd3:    nibble = disp_reg[15:12];
            3'd4:    nibble = disp_reg[19:16];
            default: nibble = disp_reg[3:0];
        endcase
    end

    lbs_glyph_decoder u_glyph (
        .nibble (nibble),
        .mode   (mode),
        .glyph  (glyph)
    );

    lbs_point_decoder u_point (
        .code     (disp_reg[22:20]),
        .bank_idx (bank_idx),
        .point    (point)
    );

    // One-hot form of the bank index.
    always_comb begin
        for (int k = 0; k < NUM_BANKS; k++) begin
            bank_onehot[k] = (bank_idx == BANK_IDX_W'(k));
        end
    end

    // Output registers: dark unless a bank is being driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_en <= '0;
            seg     <= '0;
            dim     <= 1'b0;
        end else begin
            bank_en <= drive_on ? bank_onehot : '0;
            seg     <= drive_on ? {point, glyph} : '0;
            dim     <= ~disp_reg[23];
        end
    end
endmodule

// File: rtl/lbs_checker.sv
// Property checker for led_bank_scanner. It is attached by the bind below.
module lbs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run_bit,
    input logic       b1_sel,
    input logic       grp_lo,
    input logic       bright,
    input logic [2:0] h_code,
    input logic       load,
    input logic [4:0] bank_en,
    input logic [7:0] seg,
    input logic       dim
);
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en)); // R1

    AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en != 5'd0 && $past(bank_en) != 5'd0) |-> bank_en == $past(bank_en)); // R2

    AST_RAW_EFG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en[0] && $past(b1_sel) && !$past(grp_lo)) |-> seg[6:4] == 3'd0); // R5

    AST_H_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(h_code) == 3'd0) |-> !seg[7]); // R7

    AST_LOWPOWER_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !run_bit |=> (bank_en == 5'd0 && seg == 8'd0)); // R8

    AST_LOAD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bank_en == 5'd0 && seg == 8'd0)); // R9

    AST_DIM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bright |=> !dim); // R10

    AST_DIM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !bright |=> dim); // R10
endmodule

bind led_bank_scanner lbs_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_bit (cfg_reg[0]),
    .b1_sel  (cfg_reg[1]),
    .grp_lo  (cfg_reg[6]),
    .bright  (disp_reg[23]),
    .h_code  (disp_reg[22:20]),
    .load    (load),
    .bank_en (bank_en),
    .seg     (seg),
    .dim     (dim)
);

// File: tb/led_bank_scanner_tb.sv
// Self-checking bench: sweeps nibble values, h codes and mode patterns
// against a slot-position model.
module led_bank_scanner_tb;
    localparam int CLK_HZ  = 8000;
    localparam int SCAN_HZ = 100;
    localparam int N       = CLK_HZ / (SCAN_HZ * 5);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] disp = '0;
    logic [7:0]  cfg = 8'h01;
    logic        load = 1'b0;
    logic [4:0]  bank_en;
    logic [7:0]  seg;
    logic        dim;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    led_bank_scanner #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .disp_reg (disp),
        .cfg_reg  (cfg),
        .load     (load),
        .bank_en  (bank_en),
        .seg      (seg),
        .dim      (dim)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] hex_tab(input logic [3:0] v);
        case (v)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
            4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
            4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    function automatic logic [6:0] spc_tab(input logic [3:0] v);
        case (v)
            4'h0: return 7'h00; 4'h1: return 7'h58; 4'h2: return 7'h76; 4'h3: return 7'h74;
            4'h4: return 7'h1E; 4'h5: return 7'h38; 4'h6: return 7'h54; 4'h7: return 7'h5C;
            4'h8: return 7'h73; 4'h9: return 7'h50; 4'hA: return 7'h3E; 4'hB: return 7'h1C;
            4'hC: return 7'h6E; 4'hD: return 7'h40; 4'hE: return 7'h48; default: return 7'h63;
        endcase
    endfunction

    // Expected segments for bank b (0..4): R3 R4 R5 R6 R7.
    function automatic logic [7:0] exp_seg(input int b);
        logic [3:0] nib;
        logic [6:0] g;
        logic       h;
        int         code;
        nib = disp[4*b +: 4];
        if (!cfg[b+1])                     g = hex_tab(nib);
        else if (cfg[(b < 3) ? 6 : 7])     g = spc_tab(nib);
        else                               g = {3'b000, nib};
        code = int'(disp[22:20]);
        if (code == 0)      h = 1'b0;
        else if (code == 6) h = 1'b1;
        else if (code == 7) h = (b < 2);
        else                h = (b == code - 1);
        return {h, g};
    endfunction

    // Sample cnt negedges. Slot position q starts at q0; q < 0 is the dark blank.
    task automatic run_window(input int q0, input int cnt, input string req);
        for (int i = 0; i < cnt; i++) begin
            int q;
            bit on;
            int b;
            logic [4:0] e_en;
            logic [7:0] e_seg;
            if (i > 0) @(negedge clk);
            q = q0 + i;
            on = (q >= 0) && ((q % N) != 0);
            b = (q >= 0) ? (q / N) % 5 : 0;
            e_en = on ? (5'd1 << b) : 5'd0;
            e_seg = on ? exp_seg(b) : 8'd0;
            chk(bank_en == e_en, {req, " R1 R2 bank_en"}, int'(bank_en), int'(e_en));
            chk(seg == e_seg, {req, " R3 R4 R5 R6 R7 seg"}, int'(seg), int'(e_seg));
            chk(dim == ~disp[23], "R10 dim", int'(dim), int'(~disp[23]));
        end
    endtask

    // Apply new registers with a one-clock load, then check blank and scan (R9).
    task automatic load_and_check(input logic [23:0] d, input logic [7:0] c, input int extra);
        @(negedge clk);
        disp = d;
        cfg = c;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        run_window(-(N + 1), N + 1 + 5 * N + extra, "R9");
    endtask

    initial begin
        #(4 * 190000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] pats [5];
        pats[0] = 8'h01; pats[1] = 8'hFF; pats[2] = 8'h3F; pats[3] = 8'h95; pats[4] = 8'h69;

        // R11: dark during reset.
        disp = 24'h7A_5432 | 24'h00_0001;
        repeat (4) @(negedge clk);
        chk(bank_en == 5'd0, "R11 reset bank_en", int'(bank_en), 0);
        chk(seg == 8'd0, "R11 reset seg", int'(seg), 0);
        chk(dim == 1'b0, "R11 reset dim", int'(dim), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_window(0, 6 * N, "R11");

        // Sweep: every nibble in every bank, every h code, five mode patterns.
        for (int ci = 0; ci < 5; ci++) begin
            for (int v = 0; v < 16; v++) begin
                logic [23:0] d;
                for (int k = 0; k < 5; k++) d[4*k +: 4] = 4'((v + 3 * k) % 16);
                d[22:20] = 3'(v % 8);
                d[23] = v[0];
                load_and_check(d, pats[ci], (v * 5 + ci * 3) % (5 * N));
            end
        end

        // R8: low power entered in the same cycle as a load.
        @(negedge clk);
        cfg = 8'h00;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        for (int i = 0; i < 3 * N; i++) begin
            if (i == N) disp[23] = ~disp[23];
            if (i == N + 3) load = 1'b1;
            if (i == N + 4) load = 1'b0;
            chk(bank_en == 5'd0, "R8 lowpower bank_en", int'(bank_en), 0);
            chk(seg == 8'd0, "R8 lowpower seg", int'(seg), 0);
            @(negedge clk);
        end
        // R8: leaving low power starts bank 1 with no blank slot.
        cfg = 8'h95;
        @(negedge clk);
        run_window(0, 7 * N + 3, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule